// File: doc/BRIEF.md
# Table-Stepped Center-Aligned PWM

This block is a center-aligned pulse-width modulator. Software never writes its duty register. Each step request starts a small transfer engine. The engine fetches the next two-byte duty element from a 64-byte waveform table, reading the bytes at incrementing byte addresses. It assembles them low byte first into a pending duty register. The counter counts up and then down, so the output pulse is centered on the counter valley. A pending duty is applied at the counter peak, which falls in the middle of the low time. This keeps pulses from being cut or stretched.

The channel starts disabled. While it is disabled, the output is low, the active duty is zero, the engine is idle and the table index follows the table base input. After the channel is enabled, each accepted step request consumes one table entry, and the index wraps from the last entry back to the first.

The default counter limit of 800 gives a 40 kHz period from a 64 MHz clock with no prescaler. Duty is carried with 10-bit resolution.

Top module: `tbl_pwm`

## Requirements
- R1: While `en` is low, `tbl_idx` takes the value of `tbl_base` on every clock edge. While `rst_n` is low, the output is low.
- R2: The counter visits 0 up to TOP-1, holds TOP-1 for one extra cycle, and returns down to 0, which it also holds for one extra cycle. One period is therefore 2*TOP cycles. The output is high while the count is below the active duty, so for 0 < duty < TOP each high pulse lasts exactly 2*duty cycles.
- R3: An active duty of 0 keeps the output low. An active duty of TOP or more keeps it high.
- R4: Table entry e (0 to 31) holds the 16-bit value 32*e+16. Its low byte is at byte address 2e and its high byte at 2e+1. The lower 10 bits of the assembled value are the duty.
- R5: A step request sampled high at a clock edge while enabled and idle is accepted. The engine reads the low byte on the next edge and the high byte on the edge after that. On that second edge `tbl_idx` advances by one.
- R6: A step request that arrives while a transfer is in progress is ignored. It causes no second advance.
- R7: The index wraps from 31 to 0, so the waveform repeats every 32 entries.
- R8: A newly fetched duty becomes active only at the counter peak. A pulse that is in progress when a transfer completes keeps its old width.
- R9: Taking `en` low forces the output low at once and clears the active duty to 0. Step requests are ignored while `en` is low.
- R10: After enable, the first accepted step loads the entry at `tbl_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable |
| step | input | 1 | Step request, sampled on each clock edge |
| tbl_base | input | 5 | Start entry loaded into the index while disabled |
| pwm_out | output | 1 | Center-aligned PWM output |
| tbl_idx | output | 5 | Index of the next table entry to fetch |

## Verification
The bench holds a request high across a running transfer. A design that accepted it would skip a table entry. It fires a step right after a pulse begins. A design that applied the duty immediately would return a pulse that is neither the old width nor the new one. Stepping through the end of the table exposes a missing wrap, and entries above 255 expose swapped byte order. Entries at or above the counter limit, and the zero duty left after enable, expose wrong saturation at either end. A random mix of rebasing, step bursts and gaps then checks the index and the measured pulse width against values computed from the table formula.

// File: rtl/tbl_pwm.sv
module tbl_pwm #(
  parameter int TOP       = 800,
  parameter int DUTY_W    = 10,
  parameter int TBL_BYTES = 64,
  parameter int TBL_GAIN  = 32,
  parameter int TBL_OFS   = 16,
  localparam int AW       = $clog2(TBL_BYTES),
  localparam int IDX_W    = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic [IDX_W-1:0] tbl_base,
  output logic             pwm_out,
  output logic [IDX_W-1:0] tbl_idx
);

  localparam logic [DUTY_W-1:0] TOP_M1 = DUTY_W'(TOP - 1);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} xfer_t;

  xfer_t             st;
  logic [AW-1:0]     addr;
  logic [7:0]        lo_byte;
  logic [DUTY_W-1:0] pend, duty_act, cnt;
  logic              pend_vld, up;
  logic              peak;
  logic [7:0]        rd_byte;

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    logic [15:0] v;
    v = 16'(a[AW-1:1]) * 16'(TBL_GAIN) + 16'(TBL_OFS);
    return a[0] ? v[15:8] : v[7:0];
  endfunction

  assign rd_byte = rom_byte(addr);
  assign peak    = up && (cnt == TOP_M1);
  assign pwm_out = en && (cnt < duty_act);
  assign tbl_idx = addr[AW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      up       <= 1'b1;
      duty_act <= '0;
      pend     <= '0;
      pend_vld <= 1'b0;
      st       <= S_IDLE;
      addr     <= '0;
      lo_byte  <= '0;
    end else if (!en) begin
      cnt      <= '0;
      up       <= 1'b1;
      duty_act <= '0;
      pend_vld <= 1'b0;
      st       <= S_IDLE;
      addr     <= {tbl_base, 1'b0};
    end else begin
      if (up) begin
        if (cnt == TOP_M1) up <= 1'b0;
        else cnt <= cnt + 1'b1;
      end else begin
        if (cnt == '0) up <= 1'b1;
        else cnt <= cnt - 1'b1;
      end

      if (peak && pend_vld) duty_act <= pend;

      case (st)
        S_IDLE: if (step) st <= S_LO;
        S_LO: begin
          lo_byte <= rd_byte;
          addr    <= addr + 1'b1;
          st      <= S_HI;
        end
        S_HI: begin
          pend <= DUTY_W'({rd_byte, lo_byte});
          addr <= addr + 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (st == S_HI) pend_vld <= 1'b1;
      else if (peak) pend_vld <= 1'b0;
    end
  end

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP_M1);

  a_r8_duty_at_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && duty_act != $past(duty_act)) |-> $past(peak));

  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> (st != S_LO));

  a_r5_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_LO) |=> (st == S_HI || !en));

  a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_HI) |=> (tbl_idx == IDX_W'($past(tbl_idx) + 1'b1)));

endmodule

// File: tb/tbl_pwm_bench.sv
module tbl_pwm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = 800;
  localparam int FULL = -1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, step = 1'b0;
  logic [4:0] tbl_base = 5'd3;
  logic pwm_out;
  logic [4:0] tbl_idx;

  int n_chk = 0, n_bad = 0;

  tbl_pwm u_tbl_pwm (.clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .tbl_base(tbl_base), .pwm_out(pwm_out), .tbl_idx(tbl_idx));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_duty(input int e);
    return ((e % 32) * 32 + 16) & 1023;
  endfunction

  function automatic int exp_width(input int d);
    if (d == 0) return 0;
    if (d >= TOP) return FULL;
    return 2 * d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_step(input int hold);
    @(negedge clk); step = 1'b1;
    tick(hold);
    step = 1'b0;
    tick(3);
  endtask

  task automatic measure(output int w);
    bit seen;
    seen = 0;
    for (int i = 0; i < 2*TOP+4 && !seen; i++) begin @(negedge clk); seen = !pwm_out; end
    if (!seen) begin w = FULL; return; end
    seen = 0;
    for (int i = 0; i < 2*TOP+4 && !seen; i++) begin @(negedge clk); seen = pwm_out; end
    if (!seen) begin w = 0; return; end
    w = 0;
    while (pwm_out && w < 2*TOP+4) begin w++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD*190000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w, e_idx, last, base, k;
    void'($urandom(32'd2024));
    tick(3);
    chk(pwm_out == 1'b0, "R1 reset low", pwm_out, 0);
    rst_n = 1'b1;
    tick(2);
    chk(tbl_idx == 5'd3, "R1 idx follows base", tbl_idx, 3);

    en = 1'b1;
    do_step(1);
    chk(tbl_idx == 5'd4, "R5 idx advance", tbl_idx, 4);
    tick(2*TOP+2); measure(w);
    chk(w == exp_width(exp_duty(3)), "R2 R10 R4 width of base entry", w, exp_width(exp_duty(3)));

    do_step(3);
    chk(tbl_idx == 5'd5, "R6 busy request ignored", tbl_idx, 5);
    tick(2*TOP+2);

    for (int i = 0; i < 4*TOP && !pwm_out; i++) @(negedge clk);
    for (int i = 0; i < 4*TOP && pwm_out; i++) @(negedge clk);
    for (int i = 0; i < 4*TOP && !pwm_out; i++) @(negedge clk);
    w = 1; step = 1'b1;
    @(negedge clk); step = 1'b0;
    while (pwm_out && w < 2*TOP+4) begin w++; @(negedge clk); end
    chk(w == 2*exp_duty(4), "R8 pulse in progress keeps width", w, 2*exp_duty(4));
    tick(2*TOP+2); measure(w);
    chk(w == 2*exp_duty(5), "R8 new duty after peak", w, 2*exp_duty(5));
    chk(tbl_idx == 5'd6, "R5 idx after mid-pulse step", tbl_idx, 6);

    @(negedge clk); en = 1'b0; tbl_base = 5'd30; #1;
    chk(pwm_out == 1'b0, "R9 disable forces low", pwm_out, 0);
    @(negedge clk);
    chk(tbl_idx == 5'd30, "R1 idx takes base", tbl_idx, 30);
    do_step(1);
    chk(tbl_idx == 5'd30, "R9 step ignored while disabled", tbl_idx, 30);

    en = 1'b1;
    tick(2*TOP+2); measure(w);
    chk(w == 0, "R3 R9 zero duty after enable", w, 0);
    do_step(1); do_step(1);
    chk(tbl_idx == 5'd0, "R7 index wraps", tbl_idx, 0);
    tick(2*TOP+2); measure(w);
    chk(w == FULL, "R3 duty above top stays high", w, FULL);

    base = 0;
    for (int it = 0; it < 10; it++) begin
      if ($urandom % 2 == 0) begin
        @(negedge clk); en = 1'b0; base = int'($urandom % 32); tbl_base = 5'(base);
        tick(2); en = 1'b1;
        e_idx = base;
      end else e_idx = int'(tbl_idx);
      k = 1 + int'($urandom % 40);
      for (int s = 0; s < k; s++) begin
        do_step(1 + int'($urandom % 2 == 0 ? 0 : 2));
        tick(int'($urandom % 3));
      end
      e_idx = (e_idx + k) % 32;
      chk(tbl_idx == 5'(e_idx), "R5 R6 R7 random idx", tbl_idx, e_idx);
      last = (e_idx + 31) % 32;
      tick(2*TOP+2); measure(w);
      chk(w == exp_width(exp_duty(last)), "R2 R3 R4 random width", w, exp_width(exp_duty(last)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule